// File: doc/BRIEF.md
# Set/Clear Multi-Port Pin Controller

This block is a register-mapped pin controller for a chip's general-purpose pads. It serves four bidirectional ports that are 8, 24, 13 and 6 pins wide, plus a group of 29 input-only pins and a group of 24 output-only pins. All of them sit in one 32-bit register window. Software never writes an output or direction latch directly. It writes a mask to a set register or a clear register, and only the bits that are 1 in that mask change. The pad levels come back through input-level registers, after each pad has passed through a two-flop synchronizer.

The 6-pin fourth port is packed irregularly. Its output levels share one word with the output-only group, at bits 25..30. Its direction bits share the third port's direction word, at the same bit positions. Its input levels are scattered through the shared input word. The third port also has a 13-bit alternate-function select register. This block only holds that register and drives the select value out; the multiplexing itself lives elsewhere.

The bus is a plain synchronous one: an address, a write strobe and write data in each cycle, with registered read data for the address presented in the previous cycle. Control and status pins are plain levels; there is no streaming interface.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset, every output level, every output enable, the alternate-select outputs and `bus_rdata` are all zero, so every bidirectional pin starts as an undriven input.
- R2: A write to an output-set or direction-set register raises each latch bit whose write-data bit is 1. Every other bit of that latch keeps its value.
- R3: A write to an output-clear or direction-clear register lowers each latch bit whose write-data bit is 1. Every other bit of that latch keeps its value.
- R4: An enable bit of 1 drives the pad and 0 leaves it as an input. Port 0 uses set/clear/state offsets 0x50/0x54/0x58 at bit n. Port 1 uses 0x70/0x74/0x78 at bit n. Ports 2 and 3 share offsets 0x10/0x14/0x18: port 2 pin n is bit n, and port 3 pin n is bit n+25.
- R5: The shared output word has set at 0x04, clear at 0x08 and state at 0x0C. Output-only pin n is bit n (0..23) and port 3 pin n is bit n+25. Reading 0x0C returns the whole word.
- R6: The shared input word at 0x00 holds input-only pin n at bit n, except for bits 10..14 and 24. Bits 10..14 carry port 3 pins 0..4, and bit 24 carries port 3 pin 5. Input-only pins 10..14 and 24 are therefore not readable. Bits 29..31 read zero.
- R7: A pad change made before clock edge A shows up in read data at edge A+2, when the register is addressed continuously. Read data captured at edge A+1 still shows the old level.
- R8: Port 0 output levels use set 0x44, clear 0x48 and state 0x4C. Port 1 uses 0x64/0x68/0x6C. Port 2 uses set 0x20 and clear 0x24 and has no readback.
- R9: Writes to state registers, input registers and unmapped or misaligned offsets change nothing. Set and clear registers, unmapped offsets and unimplemented bits all read as zero.
- R10: The port 2 alternate-select register has set 0x28, clear 0x2C and state 0x30. Bit n drives `p2_alt[n]`.
- R11: The input words read the synchronized pad levels at bit n, whatever the direction: port 0 at 0x40, port 1 at 0x60 and port 2 at 0x1C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the previous cycle's address |
| p0_in | input | 8 | Port 0 pad levels |
| p0_lvl | output | 8 | Port 0 output levels |
| p0_oe | output | 8 | Port 0 output enables |
| p1_in | input | 24 | Port 1 pad levels |
| p1_lvl | output | 24 | Port 1 output levels |
| p1_oe | output | 24 | Port 1 output enables |
| p2_in | input | 13 | Port 2 pad levels |
| p2_lvl | output | 13 | Port 2 output levels |
| p2_oe | output | 13 | Port 2 output enables |
| p2_alt | output | 13 | Port 2 alternate-function selects |
| p3_in | input | 6 | Port 3 pad levels |
| p3_lvl | output | 6 | Port 3 output levels |
| p3_oe | output | 6 | Port 3 output enables |
| gpi_in | input | 29 | Input-only pad levels |
| gpo_lvl | output | 24 | Output-only pin levels |

## Verification
The assertions watch every set/clear latch on every cycle. They check that a set write raises exactly the masked bits and leaves the others alone, and that a clear write lowers its masked bits. They also check that a latch holds while it is not addressed, that the synchronizer output equals the pad value from two edges earlier, and that set/clear offsets read zero. Whether each offset reaches the right latch and the right bit positions can only be shown by the bench's scenarios. This covers the scattered port 3 input bits, the shared direction word and the output-only group sharing a word with port 3. It also covers the unreadable input-only pins and the exact read latency after a pad change.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int unsigned BUS_AW = 8;
  localparam int unsigned BUS_DW = 32;

  typedef enum logic [BUS_AW-1:0] {
    RA_IN3       = 8'h00,
    RA_OUT3_SET  = 8'h04,
    RA_OUT3_CLR  = 8'h08,
    RA_OUT3_ST   = 8'h0C,
    RA_DIR23_SET = 8'h10,
    RA_DIR23_CLR = 8'h14,
    RA_DIR23_ST  = 8'h18,
    RA_IN2       = 8'h1C,
    RA_OUT2_SET  = 8'h20,
    RA_OUT2_CLR  = 8'h24,
    RA_ALT2_SET  = 8'h28,
    RA_ALT2_CLR  = 8'h2C,
    RA_ALT2_ST   = 8'h30,
    RA_IN0       = 8'h40,
    RA_OUT0_SET  = 8'h44,
    RA_OUT0_CLR  = 8'h48,
    RA_OUT0_ST   = 8'h4C,
    RA_DIR0_SET  = 8'h50,
    RA_DIR0_CLR  = 8'h54,
    RA_DIR0_ST   = 8'h58,
    RA_IN1       = 8'h60,
    RA_OUT1_SET  = 8'h64,
    RA_OUT1_CLR  = 8'h68,
    RA_OUT1_ST   = 8'h6C,
    RA_DIR1_SET  = 8'h70,
    RA_DIR1_CLR  = 8'h74,
    RA_DIR1_ST   = 8'h78
  } regaddr_e;

  // Contiguous run of ones: width bits starting at bit lo
  function automatic logic [BUS_DW-1:0] field_mask(input int unsigned width, input int unsigned lo);
    logic [63:0] m;
    m = ((64'd1 << width) - 64'd1) << lo;
    return m[BUS_DW-1:0];
  endfunction
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;

  // Edges seen since reset, saturating at two; gates the latency check
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm <= '0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) |-> (q == $past(d, 2))); // R7
endmodule

// File: rtl/pinbank_screg.sv
module pinbank_screg #(
  parameter int unsigned W    = 8,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] raise;
  logic [W-1:0] lower;

  assign raise = set_we ? (wdata & MASK) : '0;
  assign lower = clr_we ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q | raise) & ~lower & MASK;
  end

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((q & $past(wdata & MASK)) == $past(wdata & MASK))); // R2
  AST_SET_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata)))); // R2
  AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((q & $past(wdata)) == '0)); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(q)); // R9
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int unsigned P0_W       = 8,
  parameter int unsigned P1_W       = 24,
  parameter int unsigned P2_W       = 13,
  parameter int unsigned P3_W       = 6,
  parameter int unsigned GPI_W      = 29,
  parameter int unsigned GPO_W      = 24,
  parameter int unsigned P3_OUT_LO  = 25,
  parameter int unsigned P3_IN_LO   = 10,
  parameter int unsigned P3_IN_LAST = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  input  logic [P0_W-1:0]   p0_in,
  output logic [P0_W-1:0]   p0_lvl,
  output logic [P0_W-1:0]   p0_oe,
  input  logic [P1_W-1:0]   p1_in,
  output logic [P1_W-1:0]   p1_lvl,
  output logic [P1_W-1:0]   p1_oe,
  input  logic [P2_W-1:0]   p2_in,
  output logic [P2_W-1:0]   p2_lvl,
  output logic [P2_W-1:0]   p2_oe,
  output logic [P2_W-1:0]   p2_alt,
  input  logic [P3_W-1:0]   p3_in,
  output logic [P3_W-1:0]   p3_lvl,
  output logic [P3_W-1:0]   p3_oe,
  input  logic [GPI_W-1:0]  gpi_in,
  output logic [GPO_W-1:0]  gpo_lvl
);
  localparam int unsigned SYNC_W = P0_W + P1_W + P2_W + P3_W + GPI_W;
  localparam int unsigned OFS_P1 = P0_W;
  localparam int unsigned OFS_P2 = OFS_P1 + P1_W;
  localparam int unsigned OFS_P3 = OFS_P2 + P2_W;
  localparam int unsigned OFS_GI = OFS_P3 + P3_W;
  localparam logic [BUS_DW-1:0] OUT3_MASK  = field_mask(GPO_W, 0) | field_mask(P3_W, P3_OUT_LO);
  localparam logic [BUS_DW-1:0] DIR23_MASK = field_mask(P2_W, 0) | field_mask(P3_W, P3_OUT_LO);

  // ---------------- input synchronization ----------------
  logic [SYNC_W-1:0] pads_raw, pads_s;
  logic [P0_W-1:0]   p0_s;
  logic [P1_W-1:0]   p1_s;
  logic [P2_W-1:0]   p2_s;
  logic [P3_W-1:0]   p3_s;
  logic [GPI_W-1:0]  gpi_s;

  assign pads_raw = {gpi_in, p3_in, p2_in, p1_in, p0_in};

  pinbank_sync #(.W(SYNC_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pads_raw), .q(pads_s)
  );

  assign p0_s  = pads_s[OFS_P1-1:0];
  assign p1_s  = pads_s[OFS_P2-1:OFS_P1];
  assign p2_s  = pads_s[OFS_P3-1:OFS_P2];
  assign p3_s  = pads_s[OFS_GI-1:OFS_P3];
  assign gpi_s = pads_s[SYNC_W-1:OFS_GI];

  // Shared input word: input-only pins, overlaid by the scattered port 3 bits
  logic [BUS_DW-1:0] in3_word;
  always_comb begin
    in3_word = '0;
    in3_word[GPI_W-1:0] = gpi_s;
    for (int k = 0; k < int'(P3_W) - 1; k++) in3_word[P3_IN_LO + k] = p3_s[k];
    in3_word[P3_IN_LAST] = p3_s[P3_W-1];
  end

  // ---------------- write strobes ----------------
  function automatic logic hit(input logic [BUS_AW-1:0] a, input regaddr_e r);
    return bus_we && (a == r);
  endfunction

  // ---------------- latches ----------------
  logic [P0_W-1:0]   out0_q, dir0_q;
  logic [P1_W-1:0]   out1_q, dir1_q;
  logic [P2_W-1:0]   out2_q, alt2_q;
  logic [BUS_DW-1:0] out3_q, dir23_q;

  pinbank_screg #(.W(P0_W)) u_out0 (.clk(clk), .rst_n(rst_n),
    .set_we(hit(bus_addr, RA_OUT0_SET)), .clr_we(hit(bus_addr, RA_OUT0_CLR)),
    .wdata(bus_wdata[P0_W-1:0]), .q(out0_q));
  pinbank_screg #(.W(P0_W)) u_dir0 (.clk(clk), .rst_n(rst_n),
    .set_we(hit(bus_addr, RA_DIR0_SET)), .clr_we(hit(bus_addr, RA_DIR0_CLR)),
    .wdata(bus_wdata[P0_W-1:0]), .q(dir0_q));
  pinbank_screg #(.W(P1_W)) u_out1 (.clk(clk), .rst_n(rst_n),
    .set_we(hit(bus_addr, RA_OUT1_SET)), .clr_we(hit(bus_addr, RA_OUT1_CLR)),
    .wdata(bus_wdata[P1_W-1:0]), .q(out1_q));
  pinbank_screg #(.W(P1_W)) u_dir1 (.clk(clk), .rst_n(rst_n),
    .set_we(hit(bus_addr, RA_DIR1_SET)), .clr_we(hit(bus_addr, RA_DIR1_CLR)),
    .wdata(bus_wdata[P1_W-1:0]), .q(dir1_q));
  pinbank_screg #(.W(P2_W)) u_out2 (.clk(clk), .rst_n(rst_n),
    .set_we(hit(bus_addr, RA_OUT2_SET)), .clr_we(hit(bus_addr, RA_OUT2_CLR)),
    .wdata(bus_wdata[P2_W-1:0]), .q(out2_q));
  pinbank_screg #(.W(P2_W)) u_alt2 (.clk(clk), .rst_n(rst_n),
    .set_we(hit(bus_addr, RA_ALT2_SET)), .clr_we(hit(bus_addr, RA_ALT2_CLR)),
    .wdata(bus_wdata[P2_W-1:0]), .q(alt2_q));
  pinbank_screg #(.W(BUS_DW), .MASK(OUT3_MASK)) u_out3 (.clk(clk), .rst_n(rst_n),
    .set_we(hit(bus_addr, RA_OUT3_SET)), .clr_we(hit(bus_addr, RA_OUT3_CLR)),
    .wdata(bus_wdata), .q(out3_q));
  pinbank_screg #(.W(BUS_DW), .MASK(DIR23_MASK)) u_dir23 (.clk(clk), .rst_n(rst_n),
    .set_we(hit(bus_addr, RA_DIR23_SET)), .clr_we(hit(bus_addr, RA_DIR23_CLR)),
    .wdata(bus_wdata), .q(dir23_q));

  // ---------------- pad drive ----------------
  assign p0_lvl  = out0_q;
  assign p0_oe   = dir0_q;
  assign p1_lvl  = out1_q;
  assign p1_oe   = dir1_q;
  assign p2_lvl  = out2_q;
  assign p2_oe   = dir23_q[P2_W-1:0];
  assign p2_alt  = alt2_q;
  assign p3_lvl  = out3_q[P3_OUT_LO +: P3_W];
  assign p3_oe   = dir23_q[P3_OUT_LO +: P3_W];
  assign gpo_lvl = out3_q[GPO_W-1:0];

  // ---------------- read path ----------------
  logic [BUS_DW-1:0] rd_next;
  always_comb begin
    case (bus_addr)
      RA_IN3:      rd_next = in3_word;
      RA_OUT3_ST:  rd_next = out3_q;
      RA_DIR23_ST: rd_next = dir23_q;
      RA_IN2:      rd_next = BUS_DW'(p2_s);
      RA_ALT2_ST:  rd_next = BUS_DW'(alt2_q);
      RA_IN0:      rd_next = BUS_DW'(p0_s);
      RA_OUT0_ST:  rd_next = BUS_DW'(out0_q);
      RA_DIR0_ST:  rd_next = BUS_DW'(dir0_q);
      RA_IN1:      rd_next = BUS_DW'(p1_s);
      RA_OUT1_ST:  rd_next = BUS_DW'(out1_q);
      RA_DIR1_ST:  rd_next = BUS_DW'(dir1_q);
      default:     rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_next;
  end

  logic addr_is_strobe;
  assign addr_is_strobe = (bus_addr == RA_OUT3_SET)  || (bus_addr == RA_OUT3_CLR)  ||
                          (bus_addr == RA_DIR23_SET) || (bus_addr == RA_DIR23_CLR) ||
                          (bus_addr == RA_OUT2_SET)  || (bus_addr == RA_OUT2_CLR)  ||
                          (bus_addr == RA_ALT2_SET)  || (bus_addr == RA_ALT2_CLR)  ||
                          (bus_addr == RA_OUT0_SET)  || (bus_addr == RA_OUT0_CLR)  ||
                          (bus_addr == RA_DIR0_SET)  || (bus_addr == RA_DIR0_CLR)  ||
                          (bus_addr == RA_OUT1_SET)  || (bus_addr == RA_OUT1_CLR)  ||
                          (bus_addr == RA_DIR1_SET)  || (bus_addr == RA_DIR1_CLR);

  AST_STROBE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    addr_is_strobe |=> (bus_rdata == '0)); // R9
  AST_P3_DIR_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == RA_DIR23_SET) |=>
      ((p3_oe & $past(bus_wdata[P3_OUT_LO +: P3_W])) == $past(bus_wdata[P3_OUT_LO +: P3_W]))); // R4
  AST_GPO_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == RA_OUT3_CLR) |=> ((gpo_lvl & $past(bus_wdata[GPO_W-1:0])) == '0)); // R5
endmodule

// File: tb/pinbank_ctrl_bench.sv
module pinbank_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  p0_in = '0, p0_lvl, p0_oe;
  logic [23:0] p1_in = '0, p1_lvl, p1_oe;
  logic [12:0] p2_in = '0, p2_lvl, p2_oe, p2_alt;
  logic [5:0]  p3_in = '0, p3_lvl, p3_oe;
  logic [28:0] gpi_in = '0;
  logic [23:0] gpo_lvl;

  always #2 clk = ~clk;

  pinbank_ctrl u_pinbank_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata), .p0_in(p0_in), .p0_lvl(p0_lvl), .p0_oe(p0_oe),
    .p1_in(p1_in), .p1_lvl(p1_lvl), .p1_oe(p1_oe), .p2_in(p2_in), .p2_lvl(p2_lvl),
    .p2_oe(p2_oe), .p2_alt(p2_alt), .p3_in(p3_in), .p3_lvl(p3_lvl), .p3_oe(p3_oe),
    .gpi_in(gpi_in), .gpo_lvl(gpo_lvl)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Reference state, kept from the requirements
  localparam logic [31:0] M_OUT3  = 32'h7EFF_FFFF;
  localparam logic [31:0] M_DIR23 = 32'h7E00_1FFF;
  logic [7:0]  m_out0 = '0, m_dir0 = '0;
  logic [23:0] m_out1 = '0, m_dir1 = '0;
  logic [12:0] m_out2 = '0, m_alt2 = '0;
  logic [31:0] m_out3 = '0, m_dir23 = '0;

  task automatic chk(input string tag, input logic [159:0] act, input logic [159:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] in3_exp();
    logic [31:0] w;
    w = '0;
    w[28:0]  = gpi_in;
    w[14:10] = p3_in[4:0];
    w[24]    = p3_in[5];
    return w;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h00: return in3_exp();
      8'h0C: return m_out3;
      8'h18: return m_dir23;
      8'h1C: return {19'b0, p2_in};
      8'h30: return {19'b0, m_alt2};
      8'h40: return {24'b0, p0_in};
      8'h4C: return {24'b0, m_out0};
      8'h58: return {24'b0, m_dir0};
      8'h60: return {8'b0, p1_in};
      8'h6C: return {8'b0, m_out1};
      8'h78: return {8'b0, m_dir1};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h00: return "R6";
      8'h1C, 8'h40, 8'h60: return "R11";
      8'h10, 8'h14, 8'h18, 8'h50, 8'h54, 8'h58, 8'h70, 8'h74, 8'h78: return "R4";
      8'h04, 8'h08, 8'h0C: return "R5";
      8'h28, 8'h2C, 8'h30: return "R10";
      8'h20, 8'h24, 8'h44, 8'h48, 8'h4C, 8'h64, 8'h68, 8'h6C: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [7:0] pick_addr(input int unsigned i);
    if (i < 13) return 8'(i * 4);
    if (i < 20) return 8'(8'h40 + (i - 13) * 4);
    if (i < 27) return 8'(8'h60 + (i - 20) * 4);
    case (i)
      27: return 8'h34;
      28: return 8'h3C;
      29: return 8'h5C;
      30: return 8'h7C;
      31: return 8'h80;
      32: return 8'hFC;
      default: return 8'h45;
    endcase
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    case (a)
      8'h04: m_out3  = m_out3 | (d & M_OUT3);
      8'h08: m_out3  = m_out3 & ~d;
      8'h10: m_dir23 = m_dir23 | (d & M_DIR23);
      8'h14: m_dir23 = m_dir23 & ~d;
      8'h20: m_out2  = m_out2 | d[12:0];
      8'h24: m_out2  = m_out2 & ~d[12:0];
      8'h28: m_alt2  = m_alt2 | d[12:0];
      8'h2C: m_alt2  = m_alt2 & ~d[12:0];
      8'h44: m_out0  = m_out0 | d[7:0];
      8'h48: m_out0  = m_out0 & ~d[7:0];
      8'h50: m_dir0  = m_dir0 | d[7:0];
      8'h54: m_dir0  = m_dir0 & ~d[7:0];
      8'h64: m_out1  = m_out1 | d[23:0];
      8'h68: m_out1  = m_out1 & ~d[23:0];
      8'h70: m_dir1  = m_dir1 | d[23:0];
      8'h74: m_dir1  = m_dir1 & ~d[23:0];
      default: ;
    endcase
  endtask

  function automatic logic [159:0] pins_act();
    return {21'b0, p0_lvl, p0_oe, p1_lvl, p1_oe, p2_lvl, p2_oe, p2_alt, p3_lvl, p3_oe, gpo_lvl};
  endfunction

  function automatic logic [159:0] pins_exp();
    return {21'b0, m_out0, m_dir0, m_out1, m_dir1, m_out2, m_dir23[12:0], m_alt2,
            m_out3[30:25], m_dir23[30:25], m_out3[23:0]};
  endfunction

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
    model_write(a, d);
    chk((a == 8'h08 || a == 8'h14 || a == 8'h24 || a == 8'h2C || a == 8'h48 ||
         a == 8'h54 || a == 8'h68 || a == 8'h74) ? "R3 pins" : {tag_of(a), " pins"},
        pins_act(), pins_exp());
  endtask

  task automatic do_read(input logic [7:0] a);
    @(negedge clk);
    addr = a; we = 1'b0;
    @(negedge clk);
    chk({tag_of(a), " read"}, {128'b0, rdata}, {128'b0, exp_rd(a)});
  endtask

  task automatic new_pins();
    @(negedge clk);
    p0_in = 8'($urandom); p1_in = 24'($urandom); p2_in = 13'($urandom);
    p3_in = 6'($urandom); gpi_in = 29'($urandom);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd7341));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: everything low out of reset
    chk("R1 pins", pins_act(), 160'b0);
    chk("R1 rdata", {128'b0, rdata}, 160'b0);

    // R4: one write to the shared direction word enables ports 2 and 3
    do_write(8'h10, 32'hFFFF_FFFF);
    chk("R4 p2_oe", {147'b0, p2_oe}, {147'b0, 13'h1FFF});
    chk("R4 p3_oe", {154'b0, p3_oe}, {154'b0, 6'h3F});
    do_read(8'h18);
    do_write(8'h14, 32'h0200_0001);

    // R9: state register writes ignored, strobe registers read zero
    do_write(8'h44, 32'h0000_005A);
    do_write(8'h4C, 32'hFFFF_FFFF);
    chk("R9 state write ignored", {152'b0, p0_lvl}, {152'b0, 8'h5A});
    do_read(8'h44);
    do_read(8'h4C);
    do_write(8'h7C, 32'hFFFF_FFFF);
    do_read(8'h7C);

    // R5: output-only group and port 3 share one word
    do_write(8'h04, 32'hFFFF_FFFF);
    chk("R5 gpo set", {136'b0, gpo_lvl}, {136'b0, 24'hFF_FFFF});
    do_read(8'h0C);
    do_write(8'h08, 32'h4000_0001);
    chk("R5 p3 pin5 clear", {154'b0, p3_lvl}, {154'b0, 6'h1F});

    // R6: scattered port 3 input bits
    @(negedge clk); p3_in = 6'b10_0000; gpi_in = '0; repeat (3) @(negedge clk);
    do_read(8'h00);
    chk("R6 pin5 at bit 24", {128'b0, rdata}, {128'b0, 32'h0100_0000});
    @(negedge clk); p3_in = '0; gpi_in = '1; repeat (3) @(negedge clk);
    do_read(8'h00);
    chk("R6 hidden input-only bits", {128'b0, rdata}, {128'b0, 32'h1EFF_83FF});

    // R7: latency from pad change to read data
    @(negedge clk); addr = 8'h40; p0_in = 8'h00;
    repeat (4) @(negedge clk);
    p0_in = 8'hA5;
    @(negedge clk);
    @(negedge clk);
    chk("R7 old value at edge A+1", {128'b0, rdata}, 160'b0);
    @(negedge clk);
    chk("R7 new value at edge A+2", {128'b0, rdata}, {152'b0, 8'hA5});

    // Constrained random: R2 R3 R8 R10 R11 and the rest
    for (int it = 0; it < 600; it++) begin
      int unsigned sel;
      sel = $urandom % 10;
      if (sel == 0) new_pins();
      else if (sel < 6) do_write(pick_addr($urandom % 34), (($urandom % 4) == 0) ? 32'hFFFF_FFFF : $urandom);
      else do_read(pick_addr($urandom % 34));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule